// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 32-bit buses, side A and side B, and carries data between them in either direction without inverting it. The buses are split into four 8-bit lanes that work independently. Each lane has an active-low output enable, a direction input, a capture strobe and a source select for each direction. A lane either passes live data from the opposite bus or drives the value held in that direction's hold register. The hold registers load on rising strobe edges in every state of the lane, including isolation. Driving the same strobes and controls on all four lanes gives one 32-bit transceiver.

The chip-level pad ring models each three-state pin as three signals: an input vector that carries the resolved pin value, an output vector, and one drive-enable per lane and side. An output vector reads zero on any lane that is not driven. The strobes are treated as asynchronous. Each one passes through a two-flop synchronizer, and its rising edges are detected on the free-running system clock. The block carries no data stream, so it has no valid/ready handshake and no back-pressure. Every control pin is a plain level, and the outputs follow the inputs within the same cycle.

Top module: `bus_xcvr32`

## Requirements
- R1: While `rst_n` is low (sampled on a clock edge), every drive-enable is low and both hold registers of every lane are cleared. After release, a lane in stored mode drives 8'h00 until its register is loaded.
- R2: A lane whose `oe_n` bit is 1 drives neither side (`a_en` and `b_en` bits both 0), whatever its direction, select and strobe inputs are.
- R3: With `oe_n`=0 and `dir_ab`=1, the lane drives side B only (`b_en`=1, `a_en`=0). With `sel_ab`=0, the lane of `b_out` equals the same lane of `a_in` in the same cycle, bit for bit.
- R4: With `oe_n`=0, `dir_ab`=1 and `sel_ab`=1, the lane of `b_out` equals the lane's A-to-B hold register.
- R5: With `oe_n`=0 and `dir_ab`=0, the lane drives side A only (`a_en`=1, `b_en`=0). With `sel_ba`=0, the lane of `a_out` equals the same lane of `b_in` in the same cycle, bit for bit.
- R6: With `oe_n`=0, `dir_ab`=0 and `sel_ba`=1, the lane of `a_out` equals the lane's B-to-A hold register. When that register loads, `a_out` shows the new value right after the loading clock edge.
- R7: Say a strobe is first sampled high at clock edge k after being sampled low. The hold register then loads at edge k+2, taking the lane's bus value present just before that edge (A side for `cap_ab`, B side for `cap_ba`). A strobe held high loads once only.
- R8: Capture is independent of `oe_n`, `dir_ab` and the selects: a strobe edge during isolation, or with either direction set, loads the register just as in R7.
- R9: Lane n covers bits 8n+7..8n. Its controls are bit n of each control vector, and it never affects the other lanes.
- R10: When a lane drives its A side, the A-to-B register captures the value the block drives on A. When it drives its B side, the B-to-A register captures the value driven on B.
- R11: A lane of `a_out` or `b_out` whose drive-enable is 0 reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 32 | Resolved value of the side A pins |
| b_in | input | 32 | Resolved value of the side B pins |
| oe_n | input | 4 | Per-lane output enable, active low |
| dir_ab | input | 4 | Per-lane direction: 1 drives B, 0 drives A |
| cap_ab | input | 4 | Per-lane asynchronous strobe for the A-to-B hold register |
| cap_ba | input | 4 | Per-lane asynchronous strobe for the B-to-A hold register |
| sel_ab | input | 4 | Per-lane B-side source: 0 live A, 1 held value |
| sel_ba | input | 4 | Per-lane A-side source: 0 live B, 1 held value |
| a_out | output | 32 | Value driven onto side A |
| a_en | output | 4 | Per-lane drive-enable for side A |
| b_out | output | 32 | Value driven onto side B |
| b_en | output | 4 | Per-lane drive-enable for side B |

## Verification
Pass-through is first tried with a spread of byte patterns in each direction. This separates a live path from a held one, and exposes any inversion or lane swap. Strobe pulses sent during isolation and with the opposite direction show that capture does not depend on the enables. A strobe held high across a data change separates edge detection from level loading. A pulse sent while the lane is in stored mode pins down the exact cycle of the load. Strobes fired while the block itself drives the capturing side show whether the register takes the driven value or the stale external one. A long phase with random per-lane controls then checks that the lanes stay independent.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Which side of a lane is actively driven this cycle.
  typedef struct packed {
    logic drive_a;
    logic drive_b;
  } lane_path_t;

  // Reset forces isolation; otherwise enable low picks one side by direction.
  function automatic lane_path_t lane_path(input logic rst_n,
                                           input logic oe_n,
                                           input logic dir_ab);
    lane_path_t p;
    p.drive_a = rst_n & ~oe_n & ~dir_ab;
    p.drive_b = rst_n & ~oe_n &  dir_ab;
    return p;
  endfunction

endpackage

// File: rtl/xcvr_edge_sync.sv
// Brings an asynchronous strobe into the clock domain and flags its rising edge.
module xcvr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], strobe};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/xcvr_hold_reg.sv
// Lane-wide storage register with synchronous clear and load enable.
module xcvr_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/xcvr_lane.sv
// One lane: two strobe synchronizers, two hold registers, two source muxes.
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         oe_n,
  input  logic         dir_ab,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  output logic [W-1:0] a_out,
  output logic         a_en,
  output logic [W-1:0] b_out,
  output logic         b_en
);
  lane_path_t   path;
  logic         load_ab, load_ba;
  logic [W-1:0] held_ab, held_ba;
  logic [W-1:0] bus_a, bus_b;

  assign path = lane_path(rst_n, oe_n, dir_ab);
  assign a_en = path.drive_a;
  assign b_en = path.drive_b;

  xcvr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_ab (
    .clk(clk), .rst_n(rst_n), .strobe(cap_ab), .rise(load_ab));
  xcvr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_ba (
    .clk(clk), .rst_n(rst_n), .strobe(cap_ba), .rise(load_ba));

  // Driven side value is taken from this block's own output (resolved bus).
  assign bus_a = path.drive_a ? a_out : a_in;
  assign bus_b = path.drive_b ? b_out : b_in;

  xcvr_hold_reg #(.W(W)) u_held_ab (
    .clk(clk), .rst_n(rst_n), .load(load_ab), .d(bus_a), .q(held_ab));
  xcvr_hold_reg #(.W(W)) u_held_ba (
    .clk(clk), .rst_n(rst_n), .load(load_ba), .d(bus_b), .q(held_ba));

  // At most one side is driven, so the opposite side's pins are pure inputs.
  always_comb begin
    a_out = '0;
    b_out = '0;
    if (path.drive_a) a_out = sel_ba ? held_ba : b_in;
    if (path.drive_b) b_out = sel_ab ? held_ab : a_in;
  end
endmodule

// File: rtl/bus_xcvr32.sv
// Four-lane registered bidirectional transceiver.
module bus_xcvr32 #(
  parameter int LANES       = 4,
  parameter int LANE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*LANE_W-1:0] a_in,
  input  logic [LANES*LANE_W-1:0] b_in,
  input  logic [LANES-1:0]        oe_n,
  input  logic [LANES-1:0]        dir_ab,
  input  logic [LANES-1:0]        cap_ab,
  input  logic [LANES-1:0]        cap_ba,
  input  logic [LANES-1:0]        sel_ab,
  input  logic [LANES-1:0]        sel_ba,
  output logic [LANES*LANE_W-1:0] a_out,
  output logic [LANES-1:0]        a_en,
  output logic [LANES*LANE_W-1:0] b_out,
  output logic [LANES-1:0]        b_en
);
  localparam int BUS_W = LANES * LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LO = g * LANE_W;
    xcvr_lane #(.W(LANE_W), .SYNC_STAGES(SYNC_STAGES)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_in   (a_in[LO +: LANE_W]),
      .b_in   (b_in[LO +: LANE_W]),
      .oe_n   (oe_n[g]),
      .dir_ab (dir_ab[g]),
      .cap_ab (cap_ab[g]),
      .cap_ba (cap_ba[g]),
      .sel_ab (sel_ab[g]),
      .sel_ba (sel_ba[g]),
      .a_out  (a_out[LO +: LANE_W]),
      .a_en   (a_en[g]),
      .b_out  (b_out[LO +: LANE_W]),
      .b_en   (b_en[g])
    );
  end

  if (BUS_W < LANE_W) begin : g_bad_cfg
    initial $error("lane width larger than bus");
  end
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANES*LANE_W-1:0] a_in,
  input logic [LANES*LANE_W-1:0] b_in,
  input logic [LANES-1:0]        oe_n,
  input logic [LANES-1:0]        dir_ab,
  input logic [LANES-1:0]        cap_ab,
  input logic [LANES-1:0]        cap_ba,
  input logic [LANES-1:0]        sel_ab,
  input logic [LANES-1:0]        sel_ba,
  input logic [LANES*LANE_W-1:0] a_out,
  input logic [LANES-1:0]        a_en,
  input logic [LANES*LANE_W-1:0] b_out,
  input logic [LANES-1:0]        b_en
);
  // R1: reset keeps every lane isolated
  a_r1_reset_isolated: assert property (@(posedge clk)
    !rst_n |-> (a_en == '0 && b_en == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    localparam int LO = g * LANE_W;

    // R2: disabled lane drives nothing
    a_r2_isolate: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n[g] |-> (!a_en[g] && !b_en[g]));

    // R3 / R5: never both sides at once
    a_r3_one_side: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_en[g] && b_en[g]));

    // R3: live A to B
    a_r3_live_ab: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n[g] && dir_ab[g] && !sel_ab[g]) |->
        (b_en[g] && b_out[LO +: LANE_W] == a_in[LO +: LANE_W]));

    // R5: live B to A
    a_r5_live_ba: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n[g] && !dir_ab[g] && !sel_ba[g]) |->
        (a_en[g] && a_out[LO +: LANE_W] == b_in[LO +: LANE_W]));

    // R4 / R7: held B output is steady with no strobe in flight
    a_r4_held_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n[g] && dir_ab[g] && sel_ab[g] &&
       $stable(oe_n[g]) && $stable(dir_ab[g]) && $stable(sel_ab[g]) &&
       !cap_ab[g] && !$past(cap_ab[g]) && !$past(cap_ab[g], 2) &&
       !$past(cap_ab[g], 3)) |-> $stable(b_out[LO +: LANE_W]));

    // R6 / R7: held A output is steady with no strobe in flight
    a_r6_held_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n[g] && !dir_ab[g] && sel_ba[g] &&
       $stable(oe_n[g]) && $stable(dir_ab[g]) && $stable(sel_ba[g]) &&
       !cap_ba[g] && !$past(cap_ba[g]) && !$past(cap_ba[g], 2) &&
       !$past(cap_ba[g], 3)) |-> $stable(a_out[LO +: LANE_W]));

    // R11: undriven output lanes read zero
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_en[g] |-> a_out[LO +: LANE_W] == '0) and
      (!b_en[g] |-> b_out[LO +: LANE_W] == '0));
  end
endmodule

bind bus_xcvr32 xcvr_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .oe_n(oe_n),
  .dir_ab(dir_ab), .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab),
  .sel_ba(sel_ba), .a_out(a_out), .a_en(a_en), .b_out(b_out), .b_en(b_en));

// File: tb/tb_bus_xcvr32.sv
`timescale 1ns/1ps
module tb_bus_xcvr32;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a_in, b_in, a_out, b_out;
  logic [3:0]  oe_n, dir_ab, cap_ab, cap_ba, sel_ab, sel_ba, a_en, b_en;

  always #5 clk = ~clk;

  bus_xcvr32 dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .oe_n(oe_n),
    .dir_ab(dir_ab), .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab),
    .sel_ba(sel_ba), .a_out(a_out), .a_en(a_en), .b_out(b_out), .b_en(b_en));

  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;
  string cur_req = "R1";

  // external drivers of the two buses
  logic [31:0] a_ext, b_ext;
  // reference model state
  logic [7:0]  m_ab [4];
  logic [7:0]  m_ba [4];
  logic [3:0]  h1_ab, h2_ab, h3_ab, h1_ba, h2_ba, h3_ba;
  logic [31:0] e_ao, e_bo;
  logic [3:0]  e_ae, e_be;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Resolve the buses and compute the expected outputs for this cycle.
  task automatic settle();
    for (int i = 0; i < 4; i++) begin
      bit da, db;
      da = rst_n && !oe_n[i] && !dir_ab[i];
      db = rst_n && !oe_n[i] &&  dir_ab[i];
      e_ae[i] = da;
      e_be[i] = db;
      e_ao[8*i +: 8] = da ? (sel_ba[i] ? m_ba[i] : b_ext[8*i +: 8]) : 8'h00;
      e_bo[8*i +: 8] = db ? (sel_ab[i] ? m_ab[i] : a_ext[8*i +: 8]) : 8'h00;
      a_in[8*i +: 8] = da ? e_ao[8*i +: 8] : a_ext[8*i +: 8];
      b_in[8*i +: 8] = db ? e_bo[8*i +: 8] : b_ext[8*i +: 8];
    end
  endtask

  // Model update at a clock edge: load on the third sample of a new high strobe.
  task automatic model_edge();
    for (int i = 0; i < 4; i++) begin
      if (!rst_n) begin
        m_ab[i] = 8'h00; m_ba[i] = 8'h00;
        h1_ab[i] = 0; h2_ab[i] = 0; h3_ab[i] = 0;
        h1_ba[i] = 0; h2_ba[i] = 0; h3_ba[i] = 0;
      end else begin
        if (h2_ab[i] && !h3_ab[i]) m_ab[i] = a_in[8*i +: 8];
        if (h2_ba[i] && !h3_ba[i]) m_ba[i] = b_in[8*i +: 8];
        h3_ab[i] = h2_ab[i]; h2_ab[i] = h1_ab[i]; h1_ab[i] = cap_ab[i];
        h3_ba[i] = h2_ba[i]; h2_ba[i] = h1_ba[i]; h1_ba[i] = cap_ba[i];
      end
    end
  endtask

  task automatic compare();
    check(cur_req, "a_en", {28'h0, a_en}, {28'h0, e_ae});
    check(cur_req, "b_en", {28'h0, b_en}, {28'h0, e_be});
    check(cur_req, "a_out", a_out, e_ao);
    check(cur_req, "b_out", b_out, e_bo);
    // testbench drives a lane side whenever the model says the block does not
    total++;
    if ((a_en & ~e_ae) != 0 || (b_en & ~e_be) != 0) begin
      bad++;
      $display("FAIL R3/R5 bus conflict actual a_en=%b b_en=%b expected a_en=%b b_en=%b",
               a_en, b_en, e_ae, e_be);
    end
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) begin
      settle();
      #1 compare();
      @(posedge clk);
      model_edge();
      @(negedge clk);
    end
    settle();
    #1;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    oe_n = 4'hF; dir_ab = 0; cap_ab = 0; cap_ba = 0; sel_ab = 0; sel_ba = 0;
    a_ext = 32'hA5A5_A5A5; b_ext = 32'h5A5A_5A5A;
    for (int i = 0; i < 4; i++) begin m_ab[i] = 8'hxx; m_ba[i] = 8'hxx; end
    @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    oe_n = 4'h0; dir_ab = 4'hF; sel_ab = 4'hF;
    cyc(3);
    check("R1", "en during reset", {24'h0, a_en, b_en}, 32'h0);
    rst_n = 1'b1;
    cyc(2);
    check("R1", "held after reset", b_out, 32'h0);

    // R2 / R11: isolation
    cur_req = "R2/R11";
    oe_n = 4'hF; dir_ab = 4'b0101; sel_ab = 4'b0011; sel_ba = 4'b1010;
    cyc(3);
    check("R2", "isolated outputs", a_out | b_out, 32'h0);

    // R3: live A to B with several patterns
    cur_req = "R3";
    oe_n = 4'h0; dir_ab = 4'hF; sel_ab = 4'h0;
    foreach (a_ext[j]) if (j < 4) begin
      a_ext = 32'h0123_4567 << (j * 4) ^ {8{j[3:0]}};
      cyc(1);
    end
    a_ext = 32'hFF00_80_01;
    cyc(1);
    check("R3", "b_out live", b_out, 32'hFF00_8001);

    // R5: live B to A
    cur_req = "R5";
    dir_ab = 4'h0; sel_ba = 4'h0;
    b_ext = 32'hDEAD_BEEF; cyc(1);
    b_ext = 32'h0000_FFFF; cyc(1);
    check("R5", "a_out live", a_out, 32'h0000_FFFF);
    check("R5", "a_en", {28'h0, a_en}, 32'hF);

    // R7 / R8: capture while isolated, strobe held high loads once
    cur_req = "R7/R8";
    oe_n = 4'hF; a_ext = 32'h0000_0011;
    cap_ab = 4'b0001;
    cyc(5);
    a_ext = 32'h0000_0022;
    cyc(5);
    cap_ab = 4'b0000;
    cyc(2);
    oe_n = 4'b1110; dir_ab = 4'b0001; sel_ab = 4'b0001;
    cyc(1);
    check("R7", "held once", {24'h0, b_out[7:0]}, 32'h11);

    // R10: A side driven by the block, A-to-B register takes driven value
    cur_req = "R10";
    oe_n = 4'b1101; dir_ab = 4'b0000; sel_ba = 4'b0000; sel_ab = 4'b0000;
    b_ext = 32'h0000_5A00; a_ext = 32'h0000_FF00;
    cap_ab = 4'b0010; cyc(1);
    cap_ab = 4'b0000; cyc(4);
    dir_ab = 4'b0010; sel_ab = 4'b0010;
    cyc(1);
    check("R10", "resolved capture", {24'h0, b_out[15:8]}, 32'h5A);

    // R6: stored mode update timing
    cur_req = "R6";
    oe_n = 4'b1011; dir_ab = 4'b0000; sel_ba = 4'b0100;
    b_ext = 32'h003C_0000;
    cyc(1);
    check("R6", "held before", {24'h0, a_out[23:16]}, 32'h00);
    cap_ba = 4'b0100; cyc(1);
    cap_ba = 4'b0000; cyc(1);
    check("R6", "one edge short", {24'h0, a_out[23:16]}, 32'h00);
    cyc(1);
    check("R6", "after load edge", {24'h0, a_out[23:16]}, 32'h3C);

    // R4: stored A to B on lane 3
    cur_req = "R4";
    oe_n = 4'b0111; dir_ab = 4'b1000; sel_ab = 4'b1000;
    a_ext = 32'h7E00_0000; cap_ab = 4'b1000; cyc(1);
    cap_ab = 4'b0000; cyc(3);
    a_ext = 32'h1200_0000; cyc(2);
    check("R4", "held 7E", {24'h0, b_out[31:24]}, 32'h7E);

    // R9: random per-lane controls
    cur_req = "R9";
    for (int t = 0; t < 400; t++) begin
      oe_n   = 4'($urandom); dir_ab = 4'($urandom);
      sel_ab = 4'($urandom); sel_ba = 4'($urandom);
      cap_ab = 4'($urandom); cap_ba = 4'($urandom);
      a_ext  = $urandom; b_ext = $urandom;
      cyc(1 + t % 3);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule